// File: doc/BRIEF.md
# Less-Or-Equal-Zero Branch Resolver

This unit owns the fetch program counter of a small 32-bit in-order core and resolves one conditional jump: "go to PC plus offset when the operand, taken as signed, is zero or negative". Each branch instruction carries its own delay flag. When the flag is set, the instruction after the branch still runs before the target. When it is clear, the wrong-path instruction is flushed. A preceding prefix instruction can widen the branch offset from 16 to 32 bits.

The front end presents one instruction per cycle with `ins_valid`, a two-bit class code, the delay flag, the operand and the 16-bit immediate field. It accepts the instruction in any cycle where `stall` is low. Taken branches hold the front end for extra cycles through `stall`. Interrupt requests are acknowledged at once, except while a delayed branch or its slot is outstanding. During that window they are remembered and acknowledged afterwards. An instruction class that is forbidden in a slot raises `illegal_slot`.

Top module: `lez_branch_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises: `fetch_pc` is 0, `stall` is 0, no prefix is held, no delay slot is pending and no interrupt is remembered.
- R2: An accepted instruction that is not a branch and is outside a slot advances `fetch_pc` by 4 with no stall. Class codes are 0 = ordinary, 1 = prefix, 2 = branch, 3 = break. A branch with a clear delay flag whose condition fails also advances `fetch_pc` by 4 with no stall and no flush.
- R3: The branch condition is true when `ins_ra` as a signed 32-bit value is less than or equal to zero. This covers 0, -1 and 0x80000000 (taken), and 1 and 0x7FFFFFFF (not taken).
- R4: The offset is the immediate sign-extended to 32 bits. The exception is when the accepted instruction just before was a prefix: the offset is then {prefix immediate, branch immediate}.
- R5: A stored prefix applies only to the very next accepted instruction, of any class, and is discarded after it.
- R6: A taken branch with a clear delay flag raises `flush` in its accept cycle. `fetch_pc` becomes PC+offset on the next edge, and `stall` is high for the 2 following cycles (3 cycles in all).
- R7: A taken branch with the delay flag set does not flush. `fetch_pc` becomes PC+4 with 1 stall cycle. Once the slot instruction is accepted, `fetch_pc` becomes branch PC+offset.
- R8: A branch with the delay flag set whose condition fails costs no stall. Its slot runs at PC+4, and `fetch_pc` then goes to branch PC+8.
- R9: `irq_ack` follows `irq_req` in the same cycle, unless a delayed branch is being accepted or its slot is still outstanding. In that case the request is remembered and acknowledged in the cycle after the slot is accepted, for one cycle.
- R10: An accepted slot instruction of class prefix, branch or break raises `illegal_slot` in that cycle. It is then treated as ordinary: no jump, no flush, no prefix stored.
- R11: `ins_valid` is ignored while `stall` is high, so `fetch_pc` and the prefix state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Instruction present at `fetch_pc` |
| ins_kind | input | 2 | Class: 0 ordinary, 1 prefix, 2 branch, 3 break |
| ins_dly | input | 1 | Delay flag of a branch |
| ins_ra | input | 32 | Branch operand |
| ins_imm | input | 16 | Immediate field |
| irq_req | input | 1 | Interrupt or external break request |
| fetch_pc | output | 32 | PC of the next instruction to accept |
| stall | output | 1 | Front end must hold; input ignored |
| flush | output | 1 | Discard the wrong-path instruction |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| illegal_slot | output | 1 | Forbidden class seen in a delay slot |

## Verification
`flush`, `illegal_slot` and `irq_ack` are combinational, so they are due in the same cycle as the accepting input. `fetch_pc` and `stall` come from registers and change one rising edge after acceptance. The bench drives on the falling edge and reads the combinational outputs 1 ns later. It reads the registered ones at the next falling edge and then at each stall cycle, so it counts stall cycles one by one. A bench-side model built from the requirements supplies the expected PC after each instruction.

// File: rtl/lezb_pkg.sv
package lezb_pkg;
    typedef enum logic [1:0] {
        K_PLAIN  = 2'd0,
        K_PREFIX = 2'd1,
        K_BRANCH = 2'd2,
        K_BREAK  = 2'd3
    } ins_kind_e;
endpackage

// File: rtl/lezb_cond.sv
module lezb_cond #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opnd,
    output logic            take
);
    always_comb begin
        take = opnd[XLEN-1] | (opnd == '0);
    end

    // R3: zero must always select the jump
    always_comb begin
        a_r3_zero_taken: assert (opnd != '0 || take);
    end
endmodule

// File: rtl/lezb_offset.sv
module lezb_offset #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic            pfx_vld,
    input  logic [IMMW-1:0] pfx_hi,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] off
);
    logic [XLEN-1:0] sext_off;
    logic [XLEN-1:0] wide_off;

    assign sext_off = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};

    generate
        if (XLEN == 2*IMMW) begin : g_exact
            assign wide_off = {pfx_hi, imm};
        end else begin : g_ext
            assign wide_off = {{(XLEN-2*IMMW){pfx_hi[IMMW-1]}}, pfx_hi, imm};
        end
    endgenerate

    always_comb begin
        off = pfx_vld ? wide_off : sext_off;
    end
endmodule

// File: rtl/lezb_target.sv
module lezb_target #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] off,
    output logic [XLEN-1:0] jump_pc,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] skip_pc
);
    localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2*INSN_BYTES);

    always_comb begin
        jump_pc = pc + off;
        seq_pc  = pc + STEP;
        skip_pc = pc + STEP2;
    end
endmodule

// File: rtl/lez_branch_unit.sv
module lez_branch_unit #(
    parameter int XLEN           = 32,
    parameter int IMMW           = 16,
    parameter int INSN_BYTES     = 4,
    parameter int STALL_DLY_TKN  = 1,
    parameter int STALL_NODLY_TKN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [1:0]      ins_kind,
    input  logic            ins_dly,
    input  logic [XLEN-1:0] ins_ra,
    input  logic [IMMW-1:0] ins_imm,
    input  logic            irq_req,
    output logic [XLEN-1:0] fetch_pc,
    output logic            stall,
    output logic            flush,
    output logic            irq_ack,
    output logic            illegal_slot
);
    import lezb_pkg::*;

    localparam int SCW = $clog2(STALL_NODLY_TKN + 1);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] tgt;
        logic [IMMW-1:0] pfx_hi;
        logic            pfx_vld;
        logic            slot;
        logic            irq_pend;
        logic [SCW-1:0]  scnt;
    } bru_state_t;

    bru_state_t st_q, st_d;

    ins_kind_e       kind;
    logic            accept;
    logic            take;
    logic [XLEN-1:0] off;
    logic [XLEN-1:0] jump_pc, seq_pc, skip_pc;
    logic            hold_irq;
    logic            irq_any;

    assign kind   = ins_kind_e'(ins_kind);
    assign stall  = (st_q.scnt != '0);
    assign accept = ins_valid & ~stall;

    lezb_cond #(.XLEN(XLEN)) u_cond (
        .opnd (ins_ra),
        .take (take)
    );

    lezb_offset #(.XLEN(XLEN), .IMMW(IMMW)) u_off (
        .pfx_vld (st_q.pfx_vld),
        .pfx_hi  (st_q.pfx_hi),
        .imm     (ins_imm),
        .off     (off)
    );

    lezb_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc      (st_q.pc),
        .off     (off),
        .jump_pc (jump_pc),
        .seq_pc  (seq_pc),
        .skip_pc (skip_pc)
    );

    always_comb begin
        st_d         = st_q;
        flush        = 1'b0;
        illegal_slot = 1'b0;

        hold_irq = st_q.slot | (accept & ~st_q.slot & (kind == K_BRANCH) & ins_dly);
        irq_any  = irq_req | st_q.irq_pend;
        irq_ack  = irq_any & ~hold_irq;
        st_d.irq_pend = irq_any & hold_irq;

        if (stall) begin
            st_d.scnt = st_q.scnt - 1'b1;
        end

        if (accept) begin
            st_d.pfx_vld = 1'b0;
            if (st_q.slot) begin
                illegal_slot = (kind != K_PLAIN);
                st_d.slot    = 1'b0;
                st_d.pc      = st_q.tgt;
            end else begin
                unique case (kind)
                    K_PREFIX: begin
                        st_d.pfx_vld = 1'b1;
                        st_d.pfx_hi  = ins_imm;
                        st_d.pc      = seq_pc;
                    end
                    K_BRANCH: begin
                        if (ins_dly) begin
                            st_d.slot = 1'b1;
                            st_d.pc   = seq_pc;
                            st_d.tgt  = take ? jump_pc : skip_pc;
                            st_d.scnt = take ? SCW'(STALL_DLY_TKN) : '0;
                        end else if (take) begin
                            flush     = 1'b1;
                            st_d.pc   = jump_pc;
                            st_d.scnt = SCW'(STALL_NODLY_TKN);
                        end else begin
                            st_d.pc   = seq_pc;
                        end
                    end
                    default: begin
                        st_d.pc = seq_pc;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc = st_q.pc;

    // R11: held input leaves the PC alone
    a_r11_pc_frozen_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> fetch_pc == $past(fetch_pc));

    // R6: a flush is followed by the full no-delay stall
    a_r6_flush_starts_stall: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stall && st_q.scnt == SCW'(STALL_NODLY_TKN)));

    // R9: no acknowledge while a slot is outstanding
    a_r9_no_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot |-> !irq_ack);

    // R10: the illegal flag only appears for a slot instruction
    a_r10_illegal_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_slot |-> (st_q.slot && accept));

    // R7: a pending slot never flushes
    a_r7_slot_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot |-> !flush);

    // R2: ordinary instructions step by one word
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !st_q.slot && kind != K_BRANCH) |=> fetch_pc == $past(fetch_pc) + STEP);
endmodule

// File: tb/lez_branch_unit_test.sv
`timescale 1ns/1ps
module lez_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [1:0]  ins_kind = 2'd0;
    logic        ins_dly = 1'b0;
    logic [31:0] ins_ra = '0;
    logic [15:0] ins_imm = '0;
    logic        irq_req = 1'b0;
    logic [31:0] fetch_pc;
    logic        stall, flush, irq_ack, illegal_slot;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lez_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_kind(ins_kind),
        .ins_dly(ins_dly), .ins_ra(ins_ra), .ins_imm(ins_imm), .irq_req(irq_req),
        .fetch_pc(fetch_pc), .stall(stall), .flush(flush), .irq_ack(irq_ack),
        .illegal_slot(illegal_slot)
    );

    // bench-side model of the architectural state
    logic [31:0] m_pc = '0, m_tgt = '0;
    logic [15:0] m_up = '0;
    bit          m_pv = 1'b0, m_slot = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stimulus {kind, dly, ra, imm, expected stall cycles}
    localparam int NV = 18;
    localparam logic [52:0] TBL [NV] = '{
        {2'd0, 1'b0, 32'h00000000, 16'h0000, 2'd0},
        {2'd2, 1'b0, 32'h00000001, 16'h0040, 2'd0},
        {2'd2, 1'b0, 32'h00000000, 16'h0010, 2'd2},
        {2'd2, 1'b0, 32'h80000000, 16'hFFF8, 2'd2},
        {2'd1, 1'b0, 32'h00000000, 16'h0001, 2'd0},
        {2'd2, 1'b0, 32'hFFFFFFFF, 16'h0000, 2'd2},
        {2'd1, 1'b0, 32'h00000000, 16'h0002, 2'd0},
        {2'd0, 1'b0, 32'h00000000, 16'h0000, 2'd0},
        {2'd2, 1'b0, 32'h00000000, 16'hFFF0, 2'd2},
        {2'd2, 1'b0, 32'h7FFFFFFF, 16'h0020, 2'd0},
        {2'd2, 1'b1, 32'h00000000, 16'h0100, 2'd1},
        {2'd0, 1'b0, 32'h00000000, 16'h0000, 2'd0},
        {2'd2, 1'b1, 32'h00000005, 16'h0100, 2'd0},
        {2'd3, 1'b0, 32'h00000000, 16'h0000, 2'd0},
        {2'd1, 1'b0, 32'h00000000, 16'h0003, 2'd0},
        {2'd2, 1'b1, 32'h00000000, 16'h0000, 2'd1},
        {2'd2, 1'b0, 32'h00000000, 16'h0008, 2'd0},
        {2'd3, 1'b0, 32'h00000000, 16'h0000, 2'd0}
    };

    task automatic issue(input logic [1:0] k, input bit d, input logic [31:0] ra,
                         input logic [15:0] imm, input int ns);
        logic [31:0] off;
        bit taken, e_flush, e_ill, was_slot;
        string ptag;
        off   = m_pv ? {m_up, imm} : {{16{imm[15]}}, imm};
        taken = ($signed(ra) <= 0);
        was_slot = m_slot;
        e_flush = !m_slot && k == 2'd2 && taken && !d;
        e_ill   = m_slot && k != 2'd0;
        @(negedge clk);
        ins_valid = 1'b1; ins_kind = k; ins_dly = d; ins_ra = ra; ins_imm = imm;
        #1;
        chk(flush == e_flush, "R6 flush", 32'(flush), 32'(e_flush));
        chk(illegal_slot == e_ill, "R10 illegal_slot", 32'(illegal_slot), 32'(e_ill));
        if (m_slot) begin
            m_pc = m_tgt; m_slot = 1'b0; m_pv = 1'b0;
        end else begin
            case (k)
                2'd1: begin m_pv = 1'b1; m_up = imm; m_pc = m_pc + 4; end
                2'd2: begin
                    m_pv = 1'b0;
                    if (d) begin
                        m_tgt = taken ? m_pc + off : m_pc + 8;
                        m_pc = m_pc + 4; m_slot = 1'b1;
                    end else if (taken) m_pc = m_pc + off;
                    else m_pc = m_pc + 4;
                end
                default: begin m_pv = 1'b0; m_pc = m_pc + 4; end
            endcase
        end
        @(negedge clk);
        ins_valid = 1'b0;
        for (int i = 0; i < ns; i++) begin
            chk(stall == 1'b1, (d ? "R7 stall" : "R6 stall"), 32'(stall), 32'd1);
            @(negedge clk);
        end
        chk(stall == 1'b0, "R2 stall end", 32'(stall), 32'd0);
        ptag = was_slot ? "R7/R8 pc" : (k == 2'd2 ? "R3/R4 pc" : "R2/R5 pc");
        chk(fetch_pc == m_pc, ptag, fetch_pc, m_pc);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] p;
        repeat (3) @(negedge clk);
        chk(fetch_pc == 32'd0, "R1 pc", fetch_pc, 32'd0);
        chk(stall == 1'b0, "R1 stall", 32'(stall), 32'd0);
        chk(irq_ack == 1'b0, "R1 irq_ack", 32'(irq_ack), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_pc == 32'd0, "R1 pc after release", fetch_pc, 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i][52:51], TBL[i][50], TBL[i][49:18], TBL[i][17:2], int'(TBL[i][1:0]));
        end

        // R11: drive a prefix during the stall of a flushing branch
        @(negedge clk);
        p = fetch_pc;
        ins_valid = 1'b1; ins_kind = 2'd2; ins_dly = 1'b0; ins_ra = '0; ins_imm = 16'h0020;
        @(negedge clk);
        ins_kind = 2'd1; ins_imm = 16'h0007;
        chk(stall == 1'b1, "R11 stall", 32'(stall), 32'd1);
        @(negedge clk);
        chk(fetch_pc == p + 32'h20, "R11 pc held", fetch_pc, p + 32'h20);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(fetch_pc == p + 32'h20, "R11 pc held", fetch_pc, p + 32'h20);
        m_pc = p + 32'h20;
        issue(2'd2, 1'b0, 32'd0, 16'hFFFC, 2);
        chk(fetch_pc == p + 32'h1C, "R11 prefix not stored", fetch_pc, p + 32'h1C);

        // R9: plain request acknowledged at once
        @(negedge clk);
        irq_req = 1'b1; #1;
        chk(irq_ack == 1'b1, "R9 immediate ack", 32'(irq_ack), 32'd1);
        @(negedge clk);
        irq_req = 1'b0;

        // R9: request during a delayed branch is deferred past the slot
        p = fetch_pc;
        ins_valid = 1'b1; ins_kind = 2'd2; ins_dly = 1'b1; ins_ra = '0; ins_imm = 16'h0040;
        irq_req = 1'b1; #1;
        chk(irq_ack == 1'b0, "R9 held at branch", 32'(irq_ack), 32'd0);
        @(negedge clk);
        ins_valid = 1'b0; irq_req = 1'b0; #1;
        chk(irq_ack == 1'b0, "R9 held in stall", 32'(irq_ack), 32'd0);
        @(negedge clk);
        chk(fetch_pc == p + 4, "R7 slot pc", fetch_pc, p + 4);
        ins_valid = 1'b1; ins_kind = 2'd0; #1;
        chk(irq_ack == 1'b0, "R9 held at slot", 32'(irq_ack), 32'd0);
        @(negedge clk);
        ins_valid = 1'b0; #1;
        chk(irq_ack == 1'b1, "R9 deferred ack", 32'(irq_ack), 32'd1);
        chk(fetch_pc == p + 32'h40, "R7 target", fetch_pc, p + 32'h40);
        @(negedge clk);
        chk(irq_ack == 1'b0, "R9 single ack", 32'(irq_ack), 32'd0);

        // R1: reset mid-run clears PC and prefix
        ins_valid = 1'b1; ins_kind = 2'd1; ins_imm = 16'h0005;
        @(negedge clk);
        ins_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(fetch_pc == 32'd0, "R1 pc re-reset", fetch_pc, 32'd0);
        m_pc = '0; m_pv = 1'b0; m_slot = 1'b0;
        issue(2'd2, 1'b0, 32'd0, 16'h0010, 2);
        chk(fetch_pc == 32'h10, "R1 prefix cleared", fetch_pc, 32'h10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule